// File: doc/BRIEF.md
# SMBus Target Transaction Sequencer

This block sits between the bit-level engine of an I2C target and the command logic behind it. The engine reports bus events as one-cycle pulses: a start addressed for writing, a start addressed for reading, a stop, and a NACK from the controller. It also reports each received byte and each request for a byte to transmit. The sequencer turns this event stream into transactions. Written bytes are gathered into a buffer, and the buffer goes to the back end as one packet strobe with a length. A transaction that carries no bytes is reported as a quick command with its direction. Requests for read bytes are passed to the back end, and event orders that break the protocol are caught in an error state.

The write buffer is flushed either by a repeated start for reading or by a stop. Once the block enters the error state it stays there until the next stop. The first buffered byte is the command code. The buffer is `DEPTH` bytes deep, 34 by default: one command byte, one count byte and 32 data bytes. All strobe outputs are registered. Each one is high for exactly one cycle, the cycle after the event that causes it. None of the interfaces has back-pressure. Every event and byte offered is taken in the cycle it is presented, and the front end must present at most one event per cycle.

Top module: `smbus_txn_seq`

## Requirements
- R1: While `rst` is high, and after it is released, the block is idle with zero bytes stored. `in_error`, `pkt_strobe`, `quick_strobe` and `rd_byte_valid` are 0, and `pkt_len` is 0.
- R2: A write start in idle begins a write transaction. A write start in any other state moves to the error state, and `in_error` reads 1 from the next cycle.
- R3: A byte received during a write transaction is stored at the next free position. Position 0 is the first byte, it is presented on `pkt_cmd`, and byte k appears on `pkt_bytes[8k+7:8k]`.
- R4: A byte received while `DEPTH` bytes are already stored is dropped. `err_overflow` pulses for one cycle, and the stored count stays at `DEPTH`.
- R5: A stop during a write transaction with one or more bytes stored pulses `pkt_strobe` for one cycle. `pkt_len` equals the number of bytes stored.
- R6: A read start during a write transaction with bytes stored pulses `pkt_strobe` with the stored length and then enters reading. A read start in a write transaction with no bytes stored moves to the error state.
- R7: A stop with zero bytes stored pulses `quick_strobe` if the transaction was writing or reading. `quick_read` is 0 for a write and 1 for a read.
- R8: The response to a byte request is given one cycle later on `rd_byte` with `rd_byte_valid`. While reading, the response is `be_rd_byte`, or 0xFF if `be_attached` is 0. In any other state the response is 0xFF and the block moves to the error state.
- R9: A NACK while reading moves to the done state. A NACK in done has no effect. A NACK in any other state moves to the error state.
- R10: Every stop returns the block to idle with zero bytes stored, including from the error state. A stop while reading with bytes still counted pulses `err_stop_in_read`.
- R11: A byte received outside a write transaction leaves the buffer and the state unchanged and pulses `err_stray_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_wr | input | 1 | Start addressed for write (pulse) |
| ev_start_rd | input | 1 | Start addressed for read (pulse) |
| ev_stop | input | 1 | Stop condition (pulse) |
| ev_nack | input | 1 | Controller NACK after a read byte (pulse) |
| rx_valid | input | 1 | Received byte present (pulse) |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Front end asks for a byte to transmit (pulse) |
| rd_byte_valid | output | 1 | Response to `rd_req`, one cycle later |
| rd_byte | output | 8 | Byte to transmit |
| be_attached | input | 1 | Back end able to supply read data |
| be_rd_req | output | 1 | Byte request forwarded to the back end |
| be_rd_byte | input | 8 | Back end byte, sampled in the `be_rd_req` cycle |
| pkt_strobe | output | 1 | Write packet ready (one cycle) |
| pkt_len | output | $clog2(DEPTH+1) | Byte count of the last packet |
| pkt_cmd | output | 8 | First buffered byte (command code) |
| pkt_bytes | output | 8*DEPTH | Buffer contents, byte k at bits 8k+7:8k |
| quick_strobe | output | 1 | Quick command seen (one cycle) |
| quick_read | output | 1 | Direction of the quick command, 1 = read |
| in_error | output | 1 | Block is in the error state |
| err_overflow | output | 1 | Byte dropped because the buffer is full |
| err_stray_rx | output | 1 | Byte received outside a write transaction |
| err_stop_in_read | output | 1 | Stop while reading with bytes counted |

## Verification
The hardest state to reach from the ports is a stop while reading with a nonzero byte count. It occurs only when a write that actually stored bytes is turned around by a repeated read start, because that flush does not clear the count. A directed sequence writes three bytes, turns the bus around, sends a stray byte, and then stops. It checks the flush length, the stray flag, the stop-in-read flag and the unchanged buffer in turn. Buffer overflow is reached by a directed run of `DEPTH`+1 bytes, and a table of event vectors walks the state graph, including the done state and recovery from error.

// File: rtl/smbus_seq_pkg.sv
`timescale 1ns/1ps
package smbus_seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_DONE  = 3'd3,
    ST_ERR   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import smbus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_start_wr,
  input  logic       ev_start_rd,
  input  logic       ev_stop,
  input  logic       ev_nack,
  input  logic       rx_valid,
  input  logic       rd_req,
  input  logic       cnt_zero,
  output seq_state_e state_q,
  output logic       flush_now,
  output logic       append_now,
  output logic       clear_cnt,
  output logic       quick_stb_q,
  output logic       quick_dir_q,
  output logic       stop_rd_err_q,
  output logic       stray_q
);
  seq_state_e nxt;
  logic quick_req, quick_dir, stop_rd_err, stray;

  always_comb begin
    nxt         = state_q;
    flush_now   = 1'b0;
    append_now  = 1'b0;
    clear_cnt   = 1'b0;
    quick_req   = 1'b0;
    quick_dir   = 1'b0;
    stop_rd_err = 1'b0;
    stray       = 1'b0;
    if (ev_stop) begin
      nxt       = ST_IDLE;
      clear_cnt = 1'b1;
      if (cnt_zero) begin
        if (state_q == ST_WRITE || state_q == ST_READ) begin
          quick_req = 1'b1;
          quick_dir = (state_q == ST_READ);
        end
      end else if (state_q == ST_WRITE) begin
        flush_now = 1'b1;
      end else if (state_q == ST_READ) begin
        stop_rd_err = 1'b1;
      end
    end else if (ev_start_wr) begin
      nxt = (state_q == ST_IDLE) ? ST_WRITE : ST_ERR;
    end else if (ev_start_rd) begin
      case (state_q)
        ST_IDLE:  nxt = ST_READ;
        ST_WRITE: begin
          if (cnt_zero) nxt = ST_ERR;
          else begin
            flush_now = 1'b1;
            nxt       = ST_READ;
          end
        end
        default:  nxt = ST_ERR;
      endcase
    end else if (ev_nack) begin
      case (state_q)
        ST_READ: nxt = ST_DONE;
        ST_DONE: nxt = ST_DONE;
        default: nxt = ST_ERR;
      endcase
    end else if (rd_req) begin
      if (state_q != ST_READ) nxt = ST_ERR;
    end else if (rx_valid) begin
      if (state_q == ST_WRITE) append_now = 1'b1;
      else stray = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      quick_stb_q   <= 1'b0;
      quick_dir_q   <= 1'b0;
      stop_rd_err_q <= 1'b0;
      stray_q       <= 1'b0;
    end else begin
      state_q       <= nxt;
      quick_stb_q   <= quick_req;
      stop_rd_err_q <= stop_rd_err;
      stray_q       <= stray;
      if (quick_req) quick_dir_q <= quick_dir;
    end
  end

  // R10: stop always lands in idle
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> state_q == ST_IDLE);
  // R10: error is sticky until a stop
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERR && !ev_stop) |=> state_q == ST_ERR);
  // R9: NACK while reading goes to done
  assert_nack_done_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && ev_nack && !ev_stop && !ev_start_wr && !ev_start_rd)
      |=> state_q == ST_DONE);
  // R7: empty write closed by stop is a quick write
  assert_quick_write_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_stop && cnt_zero && state_q == ST_WRITE) |=> (quick_stb_q && !quick_dir_q));
  // R2: write start from idle never errors
  assert_start_wr_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && ev_start_wr && !ev_stop) |=> state_q == ST_WRITE);
endmodule

// File: rtl/seq_wrbuf.sv
`timescale 1ns/1ps
module seq_wrbuf #(
  parameter int DEPTH = 34,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 append_now,
  input  logic                 flush_now,
  input  logic                 clear_cnt,
  input  logic [7:0]           rx_byte,
  output logic                 cnt_zero,
  output logic                 pkt_strobe,
  output logic [CW-1:0]        pkt_len,
  output logic [8*DEPTH-1:0]   pkt_bytes,
  output logic                 ovf_q
);
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          take;

  assign full     = (cnt_q == CW'(DEPTH));
  assign cnt_zero = (cnt_q == '0);
  assign take     = append_now && !full;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) pkt_bytes[8*gi +: 8] <= 8'h00;
      else if (take && cnt_q == CW'(gi)) pkt_bytes[8*gi +: 8] <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      pkt_strobe <= 1'b0;
      pkt_len    <= '0;
      ovf_q      <= 1'b0;
    end else begin
      pkt_strobe <= flush_now;
      ovf_q      <= append_now && full;
      if (flush_now) pkt_len <= cnt_q;
      if (clear_cnt) cnt_q <= '0;
      else if (take) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_pkt_single_R5: assert property (@(posedge clk) disable iff (rst)
    pkt_strobe |=> !pkt_strobe);
  assert_pkt_len_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_strobe |-> pkt_len != '0);
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (full && !clear_cnt) |=> full);
endmodule

// File: rtl/seq_rdpath.sv
`timescale 1ns/1ps
module seq_rdpath (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_req,
  input  logic       in_read,
  input  logic       be_attached,
  input  logic [7:0] be_rd_byte,
  output logic       be_rd_req,
  output logic       rd_byte_valid,
  output logic [7:0] rd_byte
);
  assign be_rd_req = rd_req && in_read;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte_valid <= 1'b0;
      rd_byte       <= 8'hFF;
    end else begin
      rd_byte_valid <= rd_req;
      if (rd_req) rd_byte <= (be_rd_req && be_attached) ? be_rd_byte : 8'hFF;
    end
  end

  assert_rd_ff_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !in_read) |=> (rd_byte_valid && rd_byte == 8'hFF));
  assert_rd_valid_R8: assert property (@(posedge clk) disable iff (rst)
    rd_byte_valid |-> $past(rd_req));
endmodule

// File: rtl/smbus_txn_seq.sv
`timescale 1ns/1ps
module smbus_txn_seq
  import smbus_seq_pkg::*;
#(
  parameter int DEPTH = 34,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_start_wr,
  input  logic                 ev_start_rd,
  input  logic                 ev_stop,
  input  logic                 ev_nack,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic                 rd_req,
  output logic                 rd_byte_valid,
  output logic [7:0]           rd_byte,
  input  logic                 be_attached,
  output logic                 be_rd_req,
  input  logic [7:0]           be_rd_byte,
  output logic                 pkt_strobe,
  output logic [CW-1:0]        pkt_len,
  output logic [7:0]           pkt_cmd,
  output logic [8*DEPTH-1:0]   pkt_bytes,
  output logic                 quick_strobe,
  output logic                 quick_read,
  output logic                 in_error,
  output logic                 err_overflow,
  output logic                 err_stray_rx,
  output logic                 err_stop_in_read
);
  seq_state_e state;
  logic flush_now, append_now, clear_cnt, cnt_zero;

  seq_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd),
    .ev_stop(ev_stop), .ev_nack(ev_nack),
    .rx_valid(rx_valid), .rd_req(rd_req), .cnt_zero(cnt_zero),
    .state_q(state), .flush_now(flush_now), .append_now(append_now),
    .clear_cnt(clear_cnt), .quick_stb_q(quick_strobe), .quick_dir_q(quick_read),
    .stop_rd_err_q(err_stop_in_read), .stray_q(err_stray_rx)
  );

  seq_wrbuf #(.DEPTH(DEPTH)) u_wrbuf (
    .clk(clk), .rst(rst),
    .append_now(append_now), .flush_now(flush_now), .clear_cnt(clear_cnt),
    .rx_byte(rx_byte), .cnt_zero(cnt_zero), .pkt_strobe(pkt_strobe),
    .pkt_len(pkt_len), .pkt_bytes(pkt_bytes), .ovf_q(err_overflow)
  );

  seq_rdpath u_rdpath (
    .clk(clk), .rst(rst), .rd_req(rd_req), .in_read(state == ST_READ),
    .be_attached(be_attached), .be_rd_byte(be_rd_byte), .be_rd_req(be_rd_req),
    .rd_byte_valid(rd_byte_valid), .rd_byte(rd_byte)
  );

  assign pkt_cmd  = pkt_bytes[7:0];
  assign in_error = (state == ST_ERR);

  // R7: quick command and packet never fire together
  assert_quick_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(quick_strobe && pkt_strobe));
endmodule

// File: tb/test_smbus_txn_seq.sv
`timescale 1ns/1ps
module test_smbus_txn_seq;
  localparam int DEPTH = 34;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0;
  logic rx_valid = 0, rd_req = 0, be_attached = 1;
  logic [7:0] rx_byte = 0, be_rd_byte = 8'hA5;
  logic rd_byte_valid, be_rd_req, pkt_strobe, quick_strobe, quick_read;
  logic in_error, err_overflow, err_stray_rx, err_stop_in_read;
  logic [7:0] rd_byte, pkt_cmd;
  logic [CW-1:0] pkt_len;
  logic [8*DEPTH-1:0] pkt_bytes;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  smbus_txn_seq #(.DEPTH(DEPTH)) i_smbus_txn_seq (.*);

  // op codes: 0 write start, 1 read start, 2 stop, 3 nack, 4 rx byte, 5 byte request
  // vector: op[23:20] data[19:12] pkt,quick,qread,err[11:8] rdbyte[7:0]
  localparam int NV = 21;
  localparam logic [23:0] VEC [NV] = '{
    {4'd0, 8'h00, 4'b0000, 8'h00},  // R2 write start from idle
    {4'd4, 8'h10, 4'b0000, 8'h00},  // R3
    {4'd4, 8'h20, 4'b0000, 8'h00},  // R3
    {4'd2, 8'h00, 4'b1000, 8'h00},  // R5 flush at stop
    {4'd1, 8'h00, 4'b0000, 8'h00},  // R8 read start
    {4'd5, 8'h00, 4'b0000, 8'hA5},  // R8 back end byte
    {4'd3, 8'h00, 4'b0000, 8'h00},  // R9 read -> done
    {4'd3, 8'h00, 4'b0000, 8'h00},  // R9 nack in done ignored
    {4'd2, 8'h00, 4'b0000, 8'h00},  // R10 stop in done, nothing
    {4'd0, 8'h00, 4'b0000, 8'h00},  // R7
    {4'd2, 8'h00, 4'b0100, 8'h00},  // R7 quick write
    {4'd1, 8'h00, 4'b0000, 8'h00},  // R7
    {4'd2, 8'h00, 4'b0110, 8'h00},  // R7 quick read
    {4'd3, 8'h00, 4'b0001, 8'h00},  // R9 nack in idle -> error
    {4'd0, 8'h00, 4'b0001, 8'h00},  // R2 write start in error
    {4'd2, 8'h00, 4'b0000, 8'h00},  // R10 stop leaves error
    {4'd5, 8'h00, 4'b0001, 8'hFF},  // R8 request in idle
    {4'd2, 8'h00, 4'b0000, 8'h00},  // R10
    {4'd0, 8'h00, 4'b0000, 8'h00},  // R6
    {4'd1, 8'h00, 4'b0001, 8'h00},  // R6 read start with empty write
    {4'd2, 8'h00, 4'b0000, 8'h00}   // R10
  };
  localparam int VREQ [NV] = '{2,3,3,5,8,8,9,9,10,7,7,7,7,9,2,10,8,10,6,6,10};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one event at a falling edge, release and sample at the next one
  task automatic op(input int code, input logic [7:0] d);
    ev_start_wr = (code == 0);
    ev_start_rd = (code == 1);
    ev_stop     = (code == 2);
    ev_nack     = (code == 3);
    rx_valid    = (code == 4);
    rd_req      = (code == 5);
    rx_byte     = d;
    @(negedge clk);
    ev_start_wr = 0; ev_start_rd = 0; ev_stop = 0; ev_nack = 0;
    rx_valid = 0; rd_req = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 in_error", in_error, 0);
    chk("R1 pkt_strobe", pkt_strobe, 0);
    chk("R1 quick_strobe", quick_strobe, 0);
    chk("R1 rd_byte_valid", rd_byte_valid, 0);
    chk("R1 pkt_len", pkt_len, 0);
    rst = 0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string t;
      v = VEC[i];
      t = $sformatf("R%0d vec%0d", VREQ[i], i);
      op(int'(v[23:20]), v[19:12]);
      chk({t, " pkt"}, pkt_strobe, v[11]);
      chk({t, " quick"}, quick_strobe, v[10]);
      if (v[10]) chk({t, " qread"}, quick_read, v[9]);
      chk({t, " err"}, in_error, v[8]);
      if (v[23:20] == 4'd5) begin
        chk({t, " rdvalid"}, rd_byte_valid, 1);
        chk({t, " rdbyte"}, rd_byte, v[7:0]);
      end
    end

    // R3 R6: write three bytes, then a repeated read start
    op(0, 0); op(4, 8'h31); op(4, 8'h42); op(4, 8'h53);
    op(1, 0);
    chk("R6 flush strobe", pkt_strobe, 1);
    chk("R6 flush len", pkt_len, 3);
    chk("R3 cmd byte", pkt_cmd, 8'h31);
    chk("R3 third byte", pkt_bytes[16 +: 8], 8'h53);
    chk("R6 not error", in_error, 0);
    // R11: stray byte while reading
    op(4, 8'h99);
    chk("R11 stray flag", err_stray_rx, 1);
    chk("R11 state kept", in_error, 0);
    chk("R11 buffer kept", pkt_bytes[23:0], 24'h534231);
    chk("R11 slot3 kept", pkt_bytes[24 +: 8], 8'h00);
    // R10: stop while reading with bytes counted
    op(2, 0);
    chk("R10 stop in read", err_stop_in_read, 1);
    chk("R10 no quick", quick_strobe, 0);
    chk("R10 no packet", pkt_strobe, 0);

    // R4: overflow
    op(0, 0);
    for (int k = 0; k < DEPTH; k++) begin
      op(4, 8'(k + 1));
      if (k == DEPTH - 1) chk("R4 no ovf at full", err_overflow, 0);
    end
    op(4, 8'hEE);
    chk("R4 overflow pulse", err_overflow, 1);
    op(2, 0);
    chk("R4 ovf cleared", err_overflow, 0);
    chk("R5 packet at stop", pkt_strobe, 1);
    chk("R4 len capped", pkt_len, DEPTH);
    chk("R4 last byte", pkt_bytes[8*(DEPTH-1) +: 8], 8'(DEPTH));

    // R8: no back end attached
    be_attached = 0;
    op(1, 0); op(5, 0);
    chk("R8 detached valid", rd_byte_valid, 1);
    chk("R8 detached byte", rd_byte, 8'hFF);
    chk("R8 detached state", in_error, 0);
    op(2, 0);
    be_attached = 1;

    // R1: reset from the error state
    op(3, 0);
    chk("R9 err before reset", in_error, 1);
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk("R1 reset clears error", in_error, 0);
    op(0, 0); op(2, 0);
    chk("R1 count zero after reset", quick_strobe, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule